// File: doc/BRIEF.md
# ADC sample-and-convert sequencer

This block times one conversion of a successive-approximation ADC. A start request comes from an external trigger or from a software start input. The request is honoured only while the enable input is high. The block then opens a sample window to the analog front end, follows it with a convert phase, and when that phase ends it latches the conversion data into a result register. At that point it emits a one-cycle done strobe and sets a sticky interrupt flag.

There are two ways to set the sample window. In counted mode, a select input picks a length of 4, 8, 16 or 32 ADC clock cycles, and the trigger only has to be seen high once. In gated mode, the window follows the synchronized trigger level: it stays open while the trigger is high and closes when the trigger falls. The convert phase is 13 ADC clock cycles in both modes. The ADC clock is `clk_i`, either used directly or reduced by a divide-by-4 clock enable. The trigger may come from an unrelated clock, so it passes through a two-flop synchronizer. The bit decisions of the converter are outside this block and arrive on a plain data input.

Top module: `adc_conv_seq`

## Requirements
- R1: A conversion starts only on a rising edge of the synchronized `trig_i` or a software start, and only while `enable_i` is high. With `enable_i` low, neither source has any effect on `busy_o`, `done_o` or `irq_o`.
- R2: In counted mode (`ext_mode_i`=0), `sample_o` is high for exactly 4 << `sample_sel_i` ADC clock cycles (select 0..3 gives 4, 8, 16, 32). This holds whether the trigger falls after one ADC clock cycle or stays high beyond the end of the conversion.
- R3: In gated mode (`ext_mode_i`=1), a hardware-triggered `sample_o` is high for exactly as many ADC clock cycles as the trigger was high. `sample_sel_i` has no effect on its length.
- R4: `convert_o` rises in the cycle after `sample_o` falls and stays high for exactly 13 ADC clock cycles. The two are never high together, and `busy_o` is high over both phases and at no other time.
- R5: A software start (`sw_start_i` high for one `clk_i` cycle) always uses the counted sample length, in either mode. The request is held until the next ADC clock tick.
- R6: With `div4_i`=0 the ADC clock advances on every `clk_i` cycle. With `div4_i`=1 it advances on one `clk_i` cycle in four, and every phase length in `clk_i` cycles is multiplied by 4.
- R7: A start request that arrives while `busy_o` is high is dropped. It does not change the phase lengths of the running conversion and it does not produce an extra conversion.
- R8: `done_o` is high for one `clk_i` cycle, the cycle right after the last `convert_o` cycle. From that cycle on, `result_o` holds the `sar_data_i` value present in the last convert cycle.
- R9: `irq_o` rises together with `done_o`. It stays high until a cycle with `rd_i` or `flag_clr_i` high, and it clears in the following cycle. If a conversion ends in the same cycle as a clear request, the flag is set.
- R10: After reset, `sample_o`, `convert_o`, `busy_o`, `done_o`, `irq_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, source of the ADC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows new conversions to start |
| ext_mode_i | input | 1 | 1 = gated sample window, 0 = counted sample window |
| sample_sel_i | input | SEL_W (2) | Counted sample length select: 4 << value ADC clocks |
| div4_i | input | 1 | Turns on the divide-by-4 ADC clock enable |
| trig_i | input | 1 | Asynchronous hardware trigger |
| sw_start_i | input | 1 | Software start pulse |
| sar_data_i | input | RES_W (12) | Conversion data from the SAR stub |
| rd_i | input | 1 | Result read acknowledge, clears the flag |
| flag_clr_i | input | 1 | Direct flag clear |
| sample_o | output | 1 | Sample enable to the analog front end |
| convert_o | output | 1 | Convert phase active |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| irq_o | output | 1 | Sticky interrupt flag |
| result_o | output | RES_W (12) | Latched conversion result |

## Verification
The end of a conversion sets the interrupt flag, and a result read clears it, so the two can fall in the same cycle. The bench provokes the collision by holding `rd_i` high through an entire conversion, which puts a clear request on the very edge where the result is captured. The check passes if `irq_o` is high in the `done_o` cycle and low in the cycle after it, which shows that the set took priority and that the read still took effect on the next edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_e;

  localparam int unsigned CONV_CYCLES = 13;
  localparam int unsigned SAMPLE_BASE = 4;
endpackage

// File: rtl/adc_seq_prediv.sv
module adc_seq_prediv #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_en_i,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  // counter parked at zero while bypassed so enabling starts from a known phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!div_en_i || cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !div_en_i || (cnt_q == LAST);
endmodule

// File: rtl/adc_seq_trig_sync.sv
module adc_seq_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else if (tick_i) begin
      sync_q <= {sync_q[STAGES-2:0], trig_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             ext_mode_i,
  input  logic [SEL_W-1:0] sample_sel_i,
  input  logic             trig_lvl_i,
  input  logic             trig_rise_i,
  input  logic             sw_start_i,
  output logic             sample_o,
  output logic             convert_o,
  output logic             busy_o,
  output logic             conv_end_o
);
  localparam int unsigned MAX_SAMP  = SAMPLE_BASE << ((1 << SEL_W) - 1);
  localparam int unsigned CNT_MAX   = (MAX_SAMP > CONV_CYCLES) ? MAX_SAMP : CONV_CYCLES;
  localparam int unsigned CNT_W     = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W:0]   BASE      = (CNT_W + 1)'(SAMPLE_BASE);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gated_q, gated_d;
  logic             sw_pend_q;
  logic [CNT_W:0]   samp_len;
  logic [CNT_W-1:0] samp_last;
  logic             start_ok;

  assign samp_len  = BASE << sample_sel_i;
  assign samp_last = CNT_W'(samp_len - 1'b1);
  assign start_ok  = enable_i & (trig_rise_i | sw_start_i | sw_pend_q);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    gated_d    = gated_q;
    conv_end_o = 1'b0;
    if (tick_i) begin
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_d = ST_SAMPLE;
            cnt_d   = '0;
            gated_d = ext_mode_i & trig_rise_i;
          end
        end
        ST_SAMPLE: begin
          if (gated_q ? !trig_lvl_i : (cnt_q == samp_last)) begin
            state_d = ST_CONV;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt_q == CONV_LAST) begin
            state_d    = ST_IDLE;
            conv_end_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      gated_q   <= 1'b0;
      sw_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gated_q <= gated_d;
      // software request waits for the next ADC tick, then is consumed or dropped
      if (tick_i) sw_pend_q <= 1'b0;
      else if (sw_start_i) sw_pend_q <= 1'b1;
    end
  end

  assign sample_o  = (state_q == ST_SAMPLE);
  assign convert_o = (state_q == ST_CONV);
  assign busy_o    = (state_q != ST_IDLE);
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      done_o <= capture_i;
      if (capture_i) result_o <= data_i;
      // a finishing conversion beats a clear in the same cycle
      if (capture_i) irq_o <= 1'b1;
      else if (rd_i || clr_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned RES_W       = 12,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned PREDIV      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             ext_mode_i,
  input  logic [SEL_W-1:0] sample_sel_i,
  input  logic             div4_i,
  input  logic             trig_i,
  input  logic             sw_start_i,
  input  logic [RES_W-1:0] sar_data_i,
  input  logic             rd_i,
  input  logic             flag_clr_i,
  output logic             sample_o,
  output logic             convert_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             irq_o,
  output logic [RES_W-1:0] result_o
);
  logic tick, trig_lvl, trig_rise, conv_end;

  adc_seq_prediv #(.DIV(PREDIV)) u_prediv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_en_i (div4_i),
    .tick_o   (tick)
  );

  adc_seq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .trig_i (trig_i),
    .lvl_o  (trig_lvl),
    .rise_o (trig_rise)
  );

  adc_seq_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .enable_i     (enable_i),
    .ext_mode_i   (ext_mode_i),
    .sample_sel_i (sample_sel_i),
    .trig_lvl_i   (trig_lvl),
    .trig_rise_i  (trig_rise),
    .sw_start_i   (sw_start_i),
    .sample_o     (sample_o),
    .convert_o    (convert_o),
    .busy_o       (busy_o),
    .conv_end_o   (conv_end)
  );

  adc_seq_result #(.RES_W(RES_W)) u_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (conv_end),
    .data_i    (sar_data_i),
    .rd_i      (rd_i),
    .clr_i     (flag_clr_i),
    .result_o  (result_o),
    .done_o    (done_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic rd_i,
  input logic flag_clr_i,
  input logic sample_o,
  input logic convert_o,
  input logic busy_o,
  input logic done_o,
  input logic irq_o
);
  assert_phase_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && convert_o));

  assert_conv_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_o) |-> convert_o);

  assert_start_enabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (sample_o && $past(enable_i)));

  assert_done_after_conv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convert_o) |-> (done_o && !busy_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_irq_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> irq_o);

  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_o) && !$past(rd_i) && !$past(flag_clr_i)) |-> irq_o);
endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (.*);

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, ext_mode = 1'b0, div4 = 1'b0;
  logic [1:0]  sel = '0;
  logic        trig = 1'b0, sw_start = 1'b0, rd = 1'b0, flag_clr = 1'b0;
  logic [11:0] sar_data = '0;
  logic        sample_o, convert_o, busy_o, done_o, irq_o;
  logic [11:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_conv_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .ext_mode_i(ext_mode),
    .sample_sel_i(sel), .div4_i(div4), .trig_i(trig), .sw_start_i(sw_start),
    .sar_data_i(sar_data), .rd_i(rd), .flag_clr_i(flag_clr),
    .sample_o(sample_o), .convert_o(convert_o), .busy_o(busy_o),
    .done_o(done_o), .irq_o(irq_o), .result_o(result_o)
  );

  typedef struct packed {
    logic        ext;
    logic [1:0]  sel;
    logic        div4;
    logic        sw;
    logic [7:0]  width;
    logic [11:0] data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 8'd1,  12'hA5A},
    '{1'b0, 2'd1, 1'b0, 1'b0, 8'd2,  12'h123},
    '{1'b0, 2'd3, 1'b0, 1'b0, 8'd60, 12'hFFF},
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'd7,  12'h0F0},
    '{1'b1, 2'd3, 1'b0, 1'b0, 8'd3,  12'h801},
    '{1'b0, 2'd0, 1'b1, 1'b0, 8'd4,  12'h3C3},
    '{1'b1, 2'd2, 1'b1, 1'b0, 8'd12, 12'h555},
    '{1'b1, 2'd1, 1'b0, 1'b1, 8'd1,  12'h2AA},
    '{1'b0, 2'd0, 1'b1, 1'b1, 8'd1,  12'h7E7}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // one conversion; all counts in clk cycles observed at the falling edge
  task automatic run_conv(input bit sw, input int width,
                          output int s_cnt, output int c_cnt, output int b_cnt,
                          output int d_cnt, output int order_err,
                          output logic [11:0] res, output logic irq_d, output logic irq_n);
    int last_s, first_c, last_c, d_at;
    s_cnt = 0; c_cnt = 0; b_cnt = 0; d_cnt = 0;
    last_s = -1; first_c = -1; last_c = -1; d_at = -1;
    res = '0; irq_d = 1'b0; irq_n = 1'b0;
    @(negedge clk);
    if (sw) sw_start = 1'b1; else trig = 1'b1;
    for (int k = 1; k < 4000; k++) begin
      @(negedge clk);
      if (sw) sw_start = 1'b0;
      if (!sw && k == width) trig = 1'b0;
      if (sample_o) begin s_cnt++; last_s = k; end
      if (convert_o) begin c_cnt++; if (first_c < 0) first_c = k; last_c = k; end
      if (busy_o) b_cnt++;
      if (d_at >= 0 && k == d_at + 1) irq_n = irq_o;
      if (done_o) begin d_cnt++; d_at = k; res = result_o; irq_d = irq_o; end
      if (d_at >= 0 && k >= d_at + 24 && (sw || k > width)) break;
    end
    trig = 1'b0;
    order_err = (first_c == last_s + 1 && d_at == last_c + 1) ? 0 : 1;
  endtask

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int s, c, b, d, oe, p, s_exp;
    logic [11:0] res;
    logic irq_d, irq_n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!sample_o && !convert_o && !busy_o, "R10 phases", {sample_o, convert_o, busy_o}, 0);
    check(!done_o && !irq_o, "R10 flags", {done_o, irq_o}, 0);
    check(result_o == 0, "R10 result", result_o, 0);

    // R1 disabled: no effect
    enable = 1'b0;
    trig = 1'b1; repeat (3) @(negedge clk); trig = 1'b0;
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    b = 0; d = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (busy_o) b++;
      if (done_o || irq_o) d++;
    end
    check(b == 0 && d == 0, "R1 disabled start ignored", b + d, 0);
    enable = 1'b1;

    // vector table: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      ext_mode = VECS[i].ext; sel = VECS[i].sel; div4 = VECS[i].div4;
      sar_data = VECS[i].data;
      repeat (8) @(negedge clk);
      run_conv(VECS[i].sw, int'(VECS[i].width), s, c, b, d, oe, res, irq_d, irq_n);
      p = VECS[i].div4 ? 4 : 1;
      s_exp = (VECS[i].ext && !VECS[i].sw) ? int'(VECS[i].width) : ((4 << VECS[i].sel) * p);
      check(s == s_exp, $sformatf("R2/R3/R5/R6 sample width v%0d", i), s, s_exp);
      check(c == 13 * p, $sformatf("R4 R6 convert width v%0d", i), c, 13 * p);
      check(b == s_exp + 13 * p, $sformatf("R4 busy span v%0d", i), b, s_exp + 13 * p);
      check(d == 1, $sformatf("R8 single done v%0d", i), d, 1);
      check(oe == 0, $sformatf("R4 R8 phase order v%0d", i), oe, 0);
      check(res == VECS[i].data, $sformatf("R8 result v%0d", i), res, VECS[i].data);
    end

    // R9 sticky flag, cleared by read
    ext_mode = 1'b0; sel = 2'd0; div4 = 1'b0;
    repeat (10) @(negedge clk);
    check(irq_o == 1'b1, "R9 flag held", irq_o, 1);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    check(irq_o == 1'b0, "R9 read clears", irq_o, 0);
    sar_data = 12'h0AB;
    run_conv(1'b0, 1, s, c, b, d, oe, res, irq_d, irq_n);
    check(irq_d == 1'b1, "R9 set with done", irq_d, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(irq_o == 1'b0, "R9 clear input", irq_o, 0);

    // R9 set wins over a read in the same cycle
    rd = 1'b1;
    sar_data = 12'h456;
    run_conv(1'b0, 1, s, c, b, d, oe, res, irq_d, irq_n);
    rd = 1'b0;
    check(irq_d == 1'b1, "R9 set priority", irq_d, 1);
    check(irq_n == 1'b0, "R9 read after set", irq_n, 0);
    check(res == 12'h456, "R8 result under read", res, 12'h456);

    // R7 start requests while busy are dropped
    sel = 2'd3;
    repeat (4) @(negedge clk);
    s = 0; d = 0; b = 0;
    trig = 1'b1;
    for (int k = 1; k < 120; k++) begin
      @(negedge clk);
      if (k == 2) trig = 1'b0;
      if (k == 10) begin trig = 1'b1; b = busy_o; end
      if (k == 12) trig = 1'b0;
      if (k == 40) sw_start = 1'b1;
      if (k == 41) sw_start = 1'b0;
      if (sample_o) s++;
      if (done_o) d++;
    end
    check(b == 1, "R7 busy during sample", b, 1);
    check(s == 32, "R7 sample length kept", s, 32);
    check(d == 1, "R7 no extra conversion", d, 1);

    finish_run();
  end
endmodule